// File: doc/BRIEF.md
# Bipolar Line Receive Monitor

This block sits behind a dual-rail line receiver. Each symbol arrives as two rail bits: a mark on the positive rail, a mark on the negative rail, or a zero on both. The block captures both rails on the falling edge of the receive clock and rebuilds the data stream as NRZ. Along the way it watches the alternation of mark polarity. Any mark that repeats the polarity of the previous mark, and is not part of a legal zero substitution, raises a one-cycle violation pulse. The substitutions are three zeros and a violation, or a balancing mark, two zeros and a violation. These are decoded back to four zeros in the data stream. The NRZ output trails the rails by a fixed three-clock pipeline, so that a balancing mark can still be removed after the violation that proves it was one.

When the two rails are wired together, every mark shows up on both rails at once. After eight such dual-rail marks in a row, the block switches into NRZ pass-through mode. In that mode it forwards the positive rail and stops checking for violations. A single-rail mark returns it to bipolar mode.

A run of 255 zero symbols declares carrier loss, and the next mark clears it. Violation pulses feed an 8-bit saturating counter. A host presets the counter through a load strobe and reads it on a parallel output.

Top module: `bpv_line_monitor`

The block has two state machines. The line-mode machine has the states MODE_BIPOLAR and MODE_NRZ. It moves MODE_BIPOLAR to MODE_NRZ on the eighth consecutive dual-rail mark, and MODE_NRZ to MODE_BIPOLAR on any single-rail mark. The carrier machine has the states CARRIER_OK and CARRIER_LOST. It moves CARRIER_OK to CARRIER_LOST on the 255th consecutive zero symbol, and CARRIER_LOST to CARRIER_OK on any mark.

## Requirements
- R1: Both rails are captured on the falling edge of clk. A rail change after that edge and before the next rising edge has no effect on the symbol that was captured.
- R2: The decoded bit of a symbol captured before rising edge k appears on nrz_data after rising edge k+3. In bipolar mode, a single-rail mark decodes to 1 and a zero symbol decodes to 0.
- R3: In bipolar mode, a single-rail mark raises bpv_pulse for exactly the cycle after its rising edge when both of these hold: its polarity equals that of the last single-rail mark, and the number of zero symbols since the previous mark is 0, 1, or 4 or more. Positive polarity is pos_rail=1, neg_rail=0; negative polarity is pos_rail=0, neg_rail=1.
- R4: A same-polarity mark preceded by exactly three zeros (000V), or by exactly two zeros (B00V), is a legal substitution. It raises no pulse and decodes to 0. In the two-zero case, the preceding balancing mark also decodes to 0.
- R5: The first single-rail mark after reset is never a violation. A dual-rail symbol (both rails 1) in bipolar mode decodes to 1, raises no pulse, and leaves the stored polarity unchanged.
- R6: After eight consecutive dual-rail marks, the block is in NRZ mode. Zero symbols do not break the run, but a single-rail mark restarts it. In NRZ mode, nrz_data follows pos_rail and bpv_pulse stays 0.
- R7: In NRZ mode, a single-rail mark is still decoded as NRZ, and the block returns to bipolar mode for the next symbol.
- R8: bpv_count increments one cycle after each bpv_pulse. It saturates at 255 and does not wrap.
- R9: When cnt_load is high at a rising edge, bpv_count takes cnt_load_val. A load wins over an increment in the same cycle.
- R10: carrier_lost rises after the rising edge of the 255th consecutive zero symbol and falls after the rising edge of the next mark.
- R11: While rst_n is low, nrz_data, bpv_pulse, carrier_lost and bpv_count are 0, and the block is in bipolar mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive clock; rails are captured on its falling edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pos_rail | input | 1 | Positive-mark rail |
| neg_rail | input | 1 | Negative-mark rail |
| cnt_load | input | 1 | Preset strobe for the violation counter |
| cnt_load_val | input | 8 | Value written on preset |
| nrz_data | output | 1 | Decoded NRZ data, three clocks behind the rails |
| bpv_pulse | output | 1 | One-cycle pulse per bipolar violation |
| carrier_lost | output | 1 | High while carrier loss is declared |
| bpv_count | output | 8 | Saturating violation count |

## Verification
The hardest states to reach from the ports are the NRZ lock and the B00V substitution. NRZ lock needs eight dual-rail marks with no single-rail mark among them. B00V needs a mark of alternating polarity followed by exactly two zeros and a repeat of that polarity. Random rail symbols almost never build these, so directed sequences construct both. A sequence of seven dual-rail marks checks that the mode does not switch one mark early. The exit path is checked by two negative marks in a row: the first is decoded as NRZ and must not be flagged, and the second is decoded in bipolar mode and must be flagged.

// File: rtl/bpvmon_pkg.sv
package bpvmon_pkg;

    typedef enum logic {
        MODE_BIPOLAR = 1'b0,
        MODE_NRZ     = 1'b1
    } line_mode_e;

    typedef enum logic {
        CARRIER_OK   = 1'b0,
        CARRIER_LOST = 1'b1
    } carrier_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_sym_t;

endpackage

// File: rtl/bpvmon_rail_sampler.sv
module bpvmon_rail_sampler
    import bpvmon_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pos_rail,
    input  logic      neg_rail,
    output rail_sym_t sym
);

    // Capture both rails on the falling edge; posedge logic sees a value
    // that is stable for the whole second half of the cycle.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sym <= '0;
        end else begin
            sym.pos <= pos_rail;
            sym.neg <= neg_rail;
        end
    end

endmodule

// File: rtl/bpvmon_line_fsm.sv
module bpvmon_line_fsm
    import bpvmon_pkg::*;
#(
    parameter int NRZ_MARKS = 8,
    parameter int LOS_ZEROS = 255
) (
    input  logic       clk,
    input  logic       rst_n,
    input  rail_sym_t  sym,
    output line_mode_e mode,
    output logic       carrier_lost
);

    localparam int DUAL_W = $clog2(NRZ_MARKS + 1);
    localparam int ZERO_W = $clog2(LOS_ZEROS + 1);
    localparam logic [DUAL_W-1:0] DUAL_LAST = DUAL_W'(NRZ_MARKS - 1);
    localparam logic [ZERO_W-1:0] ZERO_LAST = ZERO_W'(LOS_ZEROS - 1);
    localparam logic [ZERO_W-1:0] ZERO_SAT  = ZERO_W'(LOS_ZEROS);

    line_mode_e        mode_q, mode_d;
    carrier_e          car_q, car_d;
    logic [DUAL_W-1:0] dual_q, dual_d;
    logic [ZERO_W-1:0] zero_q, zero_d;

    logic sym_mark, sym_dual, sym_single;

    assign sym_mark   = sym.pos | sym.neg;
    assign sym_dual   = sym.pos & sym.neg;
    assign sym_single = sym.pos ^ sym.neg;

    // State registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_BIPOLAR;
            car_q  <= CARRIER_OK;
            dual_q <= '0;
            zero_q <= '0;
        end else begin
            mode_q <= mode_d;
            car_q  <= car_d;
            dual_q <= dual_d;
            zero_q <= zero_d;
        end
    end

    // Line-mode transitions
    always_comb begin
        mode_d = mode_q;
        dual_d = dual_q;
        unique case (mode_q)
            MODE_BIPOLAR: begin
                if (sym_dual) begin
                    if (dual_q == DUAL_LAST) begin
                        mode_d = MODE_NRZ;
                    end else begin
                        dual_d = dual_q + 1'b1;
                    end
                end else if (sym_single) begin
                    dual_d = '0;
                end
            end
            MODE_NRZ: begin
                if (sym_single) begin
                    mode_d = MODE_BIPOLAR;
                    dual_d = '0;
                end
            end
        endcase
    end

    // Carrier transitions
    always_comb begin
        car_d  = car_q;
        zero_d = zero_q;
        if (sym_mark) begin
            zero_d = '0;
        end else if (zero_q != ZERO_SAT) begin
            zero_d = zero_q + 1'b1;
        end
        unique case (car_q)
            CARRIER_OK: begin
                if (!sym_mark && zero_q == ZERO_LAST) begin
                    car_d = CARRIER_LOST;
                end
            end
            CARRIER_LOST: begin
                if (sym_mark) begin
                    car_d = CARRIER_OK;
                end
            end
        endcase
    end

    // Outputs
    assign mode         = mode_q;
    assign carrier_lost = (car_q == CARRIER_LOST);

    assert_mark_clears_loss_R10: assert property (@(posedge clk) disable iff (!rst_n)
        sym_mark |=> !carrier_lost);

    assert_loss_after_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(carrier_lost) |-> !$past(sym_mark));

    assert_nrz_entry_on_dual_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_NRZ && $past(mode_q) == MODE_BIPOLAR) |-> $past(sym_dual));

endmodule

// File: rtl/bpvmon_hdb3_decoder.sv
module bpvmon_hdb3_decoder
    import bpvmon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  rail_sym_t  sym,
    input  line_mode_e mode,
    output logic       nrz_data,
    output logic       bpv_pulse
);

    // Depth 4: a B00V substitution reaches three symbols back to the B mark.
    localparam int PIPE_D = 4;
    localparam int ZRUN_W = 3;
    localparam logic [ZRUN_W-1:0] ZRUN_SAT = ZRUN_W'(4);

    logic [PIPE_D-1:0] pipe_q, pipe_d;
    logic              have_pol_q;
    logic              last_neg_q;
    logic [ZRUN_W-1:0] zrun_q;
    logic              bpv_q;

    logic sym_mark, sym_single, bipolar;
    logic same_pol, sub_ok, viol, clr_b, data_bit;

    assign sym_mark   = sym.pos | sym.neg;
    assign sym_single = sym.pos ^ sym.neg;
    assign bipolar    = (mode == MODE_BIPOLAR);

    always_comb begin
        same_pol = sym_single && have_pol_q && (sym.neg == last_neg_q);
        sub_ok   = same_pol && (zrun_q == ZRUN_W'(2) || zrun_q == ZRUN_W'(3));
        viol     = bipolar && same_pol && !sub_ok;
        clr_b    = bipolar && sub_ok && (zrun_q == ZRUN_W'(2));
        data_bit = bipolar ? (sym_mark && !sub_ok) : sym.pos;
        pipe_d   = {pipe_q[PIPE_D-2] & ~clr_b, pipe_q[PIPE_D-3:0], data_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q     <= '0;
            have_pol_q <= 1'b0;
            last_neg_q <= 1'b0;
            zrun_q     <= '0;
            bpv_q      <= 1'b0;
        end else begin
            pipe_q     <= pipe_d;
            bpv_q      <= viol;
            have_pol_q <= have_pol_q | sym_single;
            if (sym_single) begin
                last_neg_q <= sym.neg;
            end
            if (sym_mark) begin
                zrun_q <= '0;
            end else if (zrun_q != ZRUN_SAT) begin
                zrun_q <= zrun_q + 1'b1;
            end
        end
    end

    assign nrz_data  = pipe_q[PIPE_D-1];
    assign bpv_pulse = bpv_q;

    assert_quiet_in_nrz_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_NRZ) |=> !bpv_pulse);

    assert_pulse_needs_mark_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bpv_pulse |-> $past(sym_single));

endmodule

// File: rtl/bpvmon_counter.sv
module bpvmon_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (load) begin
            count <= load_val;
        end else if (inc && count != CNT_MAX) begin
            count <= count + 1'b1;
        end
    end

    assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && count == CNT_MAX) |=> count == CNT_MAX);

    assert_preset_R9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> count == $past(load_val));

endmodule

// File: rtl/bpv_line_monitor.sv
module bpv_line_monitor
    import bpvmon_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int NRZ_MARKS = 8,
    parameter int LOS_ZEROS = 255
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos_rail,
    input  logic             neg_rail,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_load_val,
    output logic             nrz_data,
    output logic             bpv_pulse,
    output logic             carrier_lost,
    output logic [CNT_W-1:0] bpv_count
);

    rail_sym_t  sym;
    line_mode_e mode;

    bpvmon_rail_sampler i_sampler (
        .clk      (clk),
        .rst_n    (rst_n),
        .pos_rail (pos_rail),
        .neg_rail (neg_rail),
        .sym      (sym)
    );

    bpvmon_line_fsm #(
        .NRZ_MARKS (NRZ_MARKS),
        .LOS_ZEROS (LOS_ZEROS)
    ) i_line_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym          (sym),
        .mode         (mode),
        .carrier_lost (carrier_lost)
    );

    bpvmon_hdb3_decoder i_decoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym       (sym),
        .mode      (mode),
        .nrz_data  (nrz_data),
        .bpv_pulse (bpv_pulse)
    );

    bpvmon_counter #(
        .CNT_W (CNT_W)
    ) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc      (bpv_pulse),
        .load     (cnt_load),
        .load_val (cnt_load_val),
        .count    (bpv_count)
    );

endmodule

// File: tb/test_bpv_line_monitor.sv
`timescale 1ns/100ps
module test_bpv_line_monitor;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pos_rail = 1'b0;
    logic       neg_rail = 1'b0;
    logic       cnt_load = 1'b0;
    logic [7:0] cnt_load_val = 8'd0;
    logic       nrz_data, bpv_pulse, carrier_lost;
    logic [7:0] bpv_count;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bpv_line_monitor i_bpv_line_monitor (
        .clk          (clk),
        .rst_n        (rst_n),
        .pos_rail     (pos_rail),
        .neg_rail     (neg_rail),
        .cnt_load     (cnt_load),
        .cnt_load_val (cnt_load_val),
        .nrz_data     (nrz_data),
        .bpv_pulse    (bpv_pulse),
        .carrier_lost (carrier_lost),
        .bpv_count    (bpv_count)
    );

    // Expected-value model built from the requirements
    int       m_dual;
    bit       m_nrz;
    int       m_zeros;
    bit       m_lost;
    bit       m_have_pol;
    bit       m_last_neg;
    int       m_zrun;
    bit [3:0] m_pipe;
    bit       m_bpv;
    int       m_count;

    function automatic void model_step(bit p, bit n, bit ld, bit [7:0] ldv);
        bit mark, single, dual, same, legit, viol, clrb, dbit;
        mark   = p | n;
        single = p ^ n;
        dual   = p & n;
        if (ld) m_count = ldv;                          // R9
        else if (m_bpv && m_count < 255) m_count++;     // R8
        same  = single && m_have_pol && (n == m_last_neg);
        legit = same && (m_zrun == 2 || m_zrun == 3);
        if (!m_nrz) begin
            dbit = legit ? 1'b0 : mark;
            viol = same && !legit;
            clrb = legit && (m_zrun == 2);
        end else begin
            dbit = p;
            viol = 1'b0;
            clrb = 1'b0;
        end
        m_pipe = {m_pipe[2] & ~clrb, m_pipe[1:0], dbit};
        m_bpv  = viol;
        if (single) begin
            m_have_pol = 1'b1;
            m_last_neg = n;
        end
        if (mark) m_zrun = 0;
        else if (m_zrun < 4) m_zrun++;
        if (!m_nrz) begin
            if (dual) begin
                if (m_dual == 7) m_nrz = 1'b1;
                else m_dual++;
            end else if (single) begin
                m_dual = 0;
            end
        end else if (single) begin
            m_nrz  = 1'b0;
            m_dual = 0;
        end
        if (mark) begin
            m_zeros = 0;
            m_lost  = 1'b0;
        end else begin
            if (!m_lost && m_zeros == 254) m_lost = 1'b1;
            if (m_zeros < 255) m_zeros++;
        end
    endfunction

    task automatic chk(string req, int got, int exp);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Drive one symbol at posedge+1, then look at the outputs at the next posedge+1
    task automatic step(bit p, bit n, bit ld = 1'b0, bit [7:0] ldv = 8'd0, bit glitch = 1'b0);
        pos_rail     = p;
        neg_rail     = n;
        cnt_load     = ld;
        cnt_load_val = ldv;
        model_step(p, n, ld, ldv);
        if (glitch) begin
            #2;
            pos_rail = ~p;
            neg_rail = ~n;
        end
        @(posedge clk);
        #1;
        chk("R2 nrz_data", int'(nrz_data), int'(m_pipe[3]));
        chk("R3 bpv_pulse", int'(bpv_pulse), int'(m_bpv));
        chk("R10 carrier_lost", int'(carrier_lost), int'(m_lost));
        chk("R8 bpv_count", int'(bpv_count), m_count);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int r;
        void'($urandom(32'd20240611));
        // R11: reset state
        repeat (3) @(posedge clk);
        #1;
        chk("R11 nrz_data in reset", int'(nrz_data), 0);
        chk("R11 bpv_pulse in reset", int'(bpv_pulse), 0);
        chk("R11 carrier_lost in reset", int'(carrier_lost), 0);
        chk("R11 bpv_count in reset", int'(bpv_count), 0);
        rst_n = 1'b1;

        // R5: first mark after reset is not a violation
        step(0, 1);
        chk("R5 first mark", int'(bpv_pulse), 0);
        step(1, 0);
        step(0, 0);
        step(1, 0);
        chk("R3 repeat after one zero", int'(bpv_pulse), 1);
        step(0, 0);
        chk("R8 count after pulse", int'(bpv_count), 1);

        // R4: 000V substitution
        step(0, 1);
        step(0, 0); step(0, 0); step(0, 0);
        step(0, 1);
        chk("R4 000V no pulse", int'(bpv_pulse), 0);
        step(0, 0); step(0, 0); step(0, 0);
        chk("R4 000V decodes zero", int'(nrz_data), 0);

        // R4: B00V substitution clears the B mark
        step(1, 0);
        step(0, 0); step(0, 0);
        step(1, 0);
        chk("R4 B00V no pulse", int'(bpv_pulse), 0);
        chk("R4 B00V balancing mark decodes zero", int'(nrz_data), 0);

        // R3: four zeros then same polarity is a violation
        step(0, 0); step(0, 0); step(0, 0); step(0, 0);
        step(1, 0);
        chk("R3 repeat after four zeros", int'(bpv_pulse), 1);

        // R5: dual-rail mark in bipolar mode keeps stored polarity
        step(1, 1);
        chk("R5 dual no pulse", int'(bpv_pulse), 0);
        step(1, 0);
        chk("R5 dual leaves polarity", int'(bpv_pulse), 1);

        // R6: seven dual marks are not enough
        for (int i = 0; i < 7; i++) begin
            step(1, 1);
            step(0, 0);
        end
        step(0, 1);
        step(0, 0); step(0, 0); step(0, 0);
        chk("R6 seven duals stay bipolar", int'(nrz_data), 1);

        // R6/R7: eight dual marks enter NRZ; single-rail mark exits
        for (int i = 0; i < 8; i++) begin
            step(1, 1);
            step(0, 0);
        end
        step(0, 1);
        chk("R6 no pulse in NRZ mode", int'(bpv_pulse), 0);
        step(0, 1);
        chk("R7 bipolar again after exit", int'(bpv_pulse), 1);
        step(0, 0); step(0, 0);
        chk("R6 NRZ follows pos rail", int'(nrz_data), 0);

        // R9 / R8: preset, saturation, load priority
        step(0, 0, 1'b1, 8'd250);
        chk("R9 preset value", int'(bpv_count), 250);
        for (int i = 0; i < 8; i++) step(1, 0);
        step(0, 0);
        chk("R8 saturates at 255", int'(bpv_count), 255);
        step(1, 0); step(1, 0); step(1, 0);
        chk("R8 no wrap", int'(bpv_count), 255);
        step(0, 0, 1'b1, 8'd10);
        chk("R9 load beats increment", int'(bpv_count), 10);
        step(0, 0);
        chk("R9 value holds", int'(bpv_count), 10);

        // R10: carrier loss boundary
        step(1, 0);
        for (int i = 0; i < 254; i++) step(0, 0);
        chk("R10 not lost after 254 zeros", int'(carrier_lost), 0);
        step(0, 0);
        chk("R10 lost after 255 zeros", int'(carrier_lost), 1);
        step(0, 0);
        step(0, 1);
        chk("R10 cleared by mark", int'(carrier_lost), 0);

        // R1: rails changed after the falling edge are ignored
        step(0, 1, 1'b0, 8'd0, 1'b1);
        chk("R1 falling-edge capture", int'(bpv_pulse), 1);

        // Constrained random mix
        for (int i = 0; i < 4000; i++) begin
            r = int'($urandom_range(0, 99));
            if (r < 40)      step(0, 0, ($urandom_range(0, 49) == 0), 8'($urandom));
            else if (r < 68) step(1, 0);
            else if (r < 96) step(0, 1);
            else             step(1, 1);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule